// File: doc/BRIEF.md
# Received Frame Buffer Router

The router sits between the frame decoder and a shared message memory. When a received frame starts, it looks at the frame identifier, picks the buffer that will hold the frame, and then turns the payload words that follow into a stream of 32-bit memory writes at consecutive word offsets inside that buffer. Each dedicated receive buffer carries an assigned identifier, a segment kind and a stored payload length. A buffer tagged static only accepts identifiers from 1 up to the static slot count. A buffer tagged dynamic only accepts identifiers above the static slot count, up to 2047.

A frame that finds no dedicated buffer falls back to a ring of FIFO buffers that follows the dedicated ones. This happens only when the FIFO is switched on and the frame gets past a value/mask rejection filter. The write position advances and wraps around the ring. When every FIFO entry is still unread, the oldest one is overwritten and an overrun pulse is raised. Every frame gets one decision pulse, which either names a target buffer or reports a drop.

Top module: `frr_router`

## Requirements
- R1: One cycle after `frm_start`, `rt_valid` pulses for exactly one cycle. An enabled buffer with `buf_dyn`=0 matches a frame whose ID equals its assigned ID and lies in 1..`nss`, and `rt_idx` then gives that buffer's number.
- R2: A buffer with `buf_dyn`=1 matches only IDs in `nss`+1..2047. A buffer whose assigned ID lies outside its own segment range never matches.
- R3: When several buffers match, the lowest-numbered buffer is chosen.
- R4: A frame ID of 0 or above 2047 gives `rt_drop`=1 with `rt_valid`, and none of its words are written.
- R5: A frame with no matching buffer is routed to the FIFO only if `fifo_en`=1 and it is not rejected. It is rejected when (ID & `rej_mask`) equals (`rej_val` & `rej_mask`). Otherwise it is dropped.
- R6: FIFO frames go to buffer `NBUF`+put. The put position starts at 0 after reset, advances by one per FIFO frame and wraps after `FDEPTH` entries.
- R7: A pulse on `fifo_pop` frees one unread entry (ignored when none is held). When `FDEPTH` entries are unread and no pop occurs in the same cycle, a FIFO frame still takes the put slot, overwriting the oldest entry, and `rt_ovr`=1 with its decision.
- R8: The number of words stored is the smaller of `frm_len` and the target's configured length (`buf_len` slice, or `fifo_len` for FIFO). Words beyond that are discarded.
- R9: Each accepted payload word appears as one full 32-bit write one cycle after it is taken. `mem_word` starts at 0 for the frame and rises by one per write, and `mem_idx` stays equal to the routed buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | Frame start strobe; descriptor valid this cycle; ends the previous frame |
| frm_fid | input | 12 | Received frame ID (values above 2047 are illegal) |
| frm_len | input | PLEN_W | Received payload length in 32-bit words |
| nss | input | 11 | Number of static slots |
| buf_en | input | NBUF | Per-buffer receive enable |
| buf_fid | input | NBUF*11 | Per-buffer assigned ID, buffer i at bits [11i+10:11i] |
| buf_dyn | input | NBUF | Per-buffer segment: 0 static, 1 dynamic |
| buf_len | input | NBUF*PLEN_W | Per-buffer configured payload length in words |
| fifo_en | input | 1 | FIFO storage switched on |
| fifo_len | input | PLEN_W | Configured payload length of FIFO buffers |
| rej_val | input | 11 | Rejection filter compare value |
| rej_mask | input | 11 | Rejection filter mask (1 = bit compared) |
| fifo_pop | input | 1 | One FIFO entry has been read out |
| wd_valid | input | 1 | Payload word valid (ignored in a `frm_start` cycle) |
| wd_data | input | 32 | Payload word |
| rt_valid | output | 1 | Routing decision pulse |
| rt_drop | output | 1 | Frame is discarded |
| rt_ovr | output | 1 | FIFO overrun: an unread entry was overwritten |
| rt_idx | output | IDX_W | Target buffer number |
| mem_we | output | 1 | Message memory word write |
| mem_idx | output | IDX_W | Buffer written |
| mem_word | output | PLEN_W | Word offset inside the buffer |
| mem_wdata | output | 32 | Word written |

## Verification
The routing function is driven with IDs that sit on each side of the static/dynamic border. Moving the border at run time shows that the segment check depends on `nss` and is not fixed to the assigned ID. A duplicated ID separates priority order from last-match behaviour. A buffer placed in the wrong segment separates the segment check from a plain ID compare. Lengths above, at and below the configured lengths separate truncation from pass-through. A long run of FIFO frames with pops mixed in shows put wrapping, overrun on a full ring, and the freed entry after a pop, while illegal, rejected and FIFO-disabled frames each test a different drop path.

// File: rtl/frr_pkg.sv
package frr_pkg;
    localparam int FID_W   = 11;
    localparam int MAX_FID = 2047;
    localparam int WORD_W  = 32;

    typedef enum logic {SEG_STATIC = 1'b0, SEG_DYNAMIC = 1'b1} seg_e;

    // frame id carries one extra bit so illegal values can be seen
    function automatic logic fid_legal(input logic [FID_W:0] fid);
        return (fid != '0) && (fid <= (FID_W+1)'(MAX_FID));
    endfunction

    function automatic logic fid_in_seg(input logic [FID_W:0] fid,
                                        input logic [FID_W-1:0] nss,
                                        input seg_e seg);
        logic [FID_W:0] lim;
        lim = {1'b0, nss};
        if (seg == SEG_STATIC)
            return (fid != '0) && (fid <= lim);
        return (fid > lim) && (fid <= (FID_W+1)'(MAX_FID));
    endfunction

    function automatic logic fid_rejected(input logic [FID_W-1:0] fid,
                                          input logic [FID_W-1:0] val,
                                          input logic [FID_W-1:0] mask);
        return (fid & mask) == (val & mask);
    endfunction
endpackage

// File: rtl/frr_match.sv
module frr_match
    import frr_pkg::*;
#(
    parameter int NBUF   = 4,
    parameter int PLEN_W = 7,
    localparam int BI_W  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic [FID_W:0]          fid,
    input  logic [FID_W-1:0]        nss,
    input  logic [NBUF-1:0]         buf_en,
    input  logic [NBUF*FID_W-1:0]   buf_fid,
    input  logic [NBUF-1:0]         buf_dyn,
    input  logic [NBUF*PLEN_W-1:0]  buf_len,
    output logic                    hit,
    output logic [BI_W-1:0]         hit_idx,
    output logic [PLEN_W-1:0]       hit_len
);
    logic [NBUF-1:0] cand;

    for (genvar i = 0; i < NBUF; i++) begin : g_cand
        assign cand[i] = buf_en[i]
                      && ({1'b0, buf_fid[i*FID_W +: FID_W]} == fid)
                      && fid_in_seg(fid, nss, seg_e'(buf_dyn[i]));
    end

    // lowest numbered candidate wins: scan from the top down
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        hit_len = '0;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit     = 1'b1;
                hit_idx = BI_W'(i);
                hit_len = buf_len[i*PLEN_W +: PLEN_W];
            end
        end
    end
endmodule

// File: rtl/frr_fifo_ptr.sv
module frr_fifo_ptr #(
    parameter int FDEPTH = 4,
    localparam int PW    = (FDEPTH > 1) ? $clog2(FDEPTH) : 1,
    localparam int CW    = $clog2(FDEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    output logic [PW-1:0] put,
    output logic          full_now
);
    logic [CW-1:0] fill;
    logic          pop_ok;

    assign pop_ok   = pop && (fill != '0);
    assign full_now = (fill == CW'(FDEPTH)) && !pop_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            put  <= '0;
            fill <= '0;
        end else begin
            if (push)
                put <= (put == PW'(FDEPTH - 1)) ? '0 : put + 1'b1;
            case ({push && !full_now, pop_ok})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/frr_writer.sv
module frr_writer
    import frr_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int PLEN_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              load_store,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic [PLEN_W-1:0] load_lim,
    input  logic              wd_valid,
    input  logic [WORD_W-1:0] wd_data,
    output logic              mem_we,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [PLEN_W-1:0] mem_word,
    output logic [WORD_W-1:0] mem_wdata
);
    logic              active;
    logic [IDX_W-1:0]  cur_idx;
    logic [PLEN_W-1:0] lim, cnt;
    logic              take;

    assign take = wd_valid && !load && active && (cnt < lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            cur_idx   <= '0;
            lim       <= '0;
            cnt       <= '0;
            mem_we    <= 1'b0;
            mem_idx   <= '0;
            mem_word  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= take;
            if (load) begin
                active  <= load_store;
                cur_idx <= load_idx;
                lim     <= load_lim;
                cnt     <= '0;
            end else if (take) begin
                cnt       <= cnt + 1'b1;
                mem_idx   <= cur_idx;
                mem_word  <= cnt;
                mem_wdata <= wd_data;
            end
        end
    end
endmodule

// File: rtl/frr_router.sv
module frr_router
    import frr_pkg::*;
#(
    parameter int NBUF   = 4,
    parameter int FDEPTH = 4,
    parameter int PLEN_W = 7,
    localparam int IDX_W = $clog2(NBUF + FDEPTH),
    localparam int BI_W  = (NBUF > 1) ? $clog2(NBUF) : 1,
    localparam int PW    = (FDEPTH > 1) ? $clog2(FDEPTH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frm_start,
    input  logic [FID_W:0]          frm_fid,
    input  logic [PLEN_W-1:0]       frm_len,
    input  logic [FID_W-1:0]        nss,
    input  logic [NBUF-1:0]         buf_en,
    input  logic [NBUF*FID_W-1:0]   buf_fid,
    input  logic [NBUF-1:0]         buf_dyn,
    input  logic [NBUF*PLEN_W-1:0]  buf_len,
    input  logic                    fifo_en,
    input  logic [PLEN_W-1:0]       fifo_len,
    input  logic [FID_W-1:0]        rej_val,
    input  logic [FID_W-1:0]        rej_mask,
    input  logic                    fifo_pop,
    input  logic                    wd_valid,
    input  logic [WORD_W-1:0]       wd_data,
    output logic                    rt_valid,
    output logic                    rt_drop,
    output logic                    rt_ovr,
    output logic [IDX_W-1:0]        rt_idx,
    output logic                    mem_we,
    output logic [IDX_W-1:0]        mem_idx,
    output logic [PLEN_W-1:0]       mem_word,
    output logic [WORD_W-1:0]       mem_wdata
);
    logic              hit, legal, to_fifo, store, push, full_now;
    logic [BI_W-1:0]   hit_idx;
    logic [PLEN_W-1:0] hit_len, cfg_len, lim;
    logic [PW-1:0]     put;
    logic [IDX_W-1:0]  tgt;

    frr_match #(.NBUF(NBUF), .PLEN_W(PLEN_W)) u_match (
        .fid(frm_fid), .nss(nss), .buf_en(buf_en), .buf_fid(buf_fid),
        .buf_dyn(buf_dyn), .buf_len(buf_len),
        .hit(hit), .hit_idx(hit_idx), .hit_len(hit_len)
    );

    frr_fifo_ptr #(.FDEPTH(FDEPTH)) u_fptr (
        .clk(clk), .rst(rst), .push(push), .pop(fifo_pop),
        .put(put), .full_now(full_now)
    );

    always_comb begin
        legal   = fid_legal(frm_fid);
        to_fifo = legal && !hit && fifo_en
               && !fid_rejected(frm_fid[FID_W-1:0], rej_val, rej_mask);
        store   = legal && (hit || to_fifo);
        push    = frm_start && to_fifo;
        tgt     = hit ? IDX_W'(hit_idx) : IDX_W'(NBUF) + IDX_W'(put);
        cfg_len = hit ? hit_len : fifo_len;
        lim     = (frm_len < cfg_len) ? frm_len : cfg_len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rt_valid <= 1'b0;
            rt_drop  <= 1'b0;
            rt_ovr   <= 1'b0;
            rt_idx   <= '0;
        end else begin
            rt_valid <= frm_start;
            rt_drop  <= frm_start && !store;
            rt_ovr   <= push && full_now;
            if (frm_start)
                rt_idx <= store ? tgt : '0;
        end
    end

    frr_writer #(.IDX_W(IDX_W), .PLEN_W(PLEN_W)) u_wr (
        .clk(clk), .rst(rst), .load(frm_start), .load_store(store),
        .load_idx(tgt), .load_lim(lim), .wd_valid(wd_valid), .wd_data(wd_data),
        .mem_we(mem_we), .mem_idx(mem_idx), .mem_word(mem_word),
        .mem_wdata(mem_wdata)
    );
endmodule

// File: rtl/frr_router_chk.sv
module frr_router_chk
    import frr_pkg::*;
#(
    parameter int NBUF   = 4,
    parameter int FDEPTH = 4,
    parameter int PLEN_W = 7,
    localparam int IDX_W = $clog2(NBUF + FDEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              frm_start,
    input logic [FID_W:0]    frm_fid,
    input logic              rt_valid,
    input logic              rt_drop,
    input logic              rt_ovr,
    input logic [IDX_W-1:0]  rt_idx,
    input logic              mem_we,
    input logic [IDX_W-1:0]  mem_idx,
    input logic [PLEN_W-1:0] mem_word
);
    // R1: exactly one decision per frame start, one cycle later
    a_r1_decision_pulse: assert property (@(posedge clk) disable iff (rst)
        frm_start |=> rt_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !frm_start |=> !rt_valid);
    // R4: illegal identifiers are dropped
    a_r4_illegal_drop: assert property (@(posedge clk) disable iff (rst)
        frm_start && (frm_fid == '0 || frm_fid > (FID_W+1)'(MAX_FID))
        |=> rt_valid && rt_drop);
    // R6: a stored frame always lands inside the buffer range
    a_r6_idx_range: assert property (@(posedge clk) disable iff (rst)
        rt_valid && !rt_drop |-> int'(rt_idx) < NBUF + FDEPTH);
    // R7: overrun only ever goes with a FIFO destination
    a_r7_ovr_fifo_only: assert property (@(posedge clk) disable iff (rst)
        rt_ovr |-> rt_valid && !rt_drop && int'(rt_idx) >= NBUF);
    // R9: back-to-back writes stay in one buffer at rising offsets
    a_r9_word_step: assert property (@(posedge clk) disable iff (rst)
        mem_we && $past(mem_we) |-> mem_idx == $past(mem_idx)
                                  && mem_word == $past(mem_word) + 1'b1);
    // R9: no word is written in the decision cycle
    a_r9_no_write_on_decision: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !rt_valid);
endmodule

bind frr_router frr_router_chk #(.NBUF(NBUF), .FDEPTH(FDEPTH), .PLEN_W(PLEN_W)) u_chk (
    .clk(clk), .rst(rst), .frm_start(frm_start), .frm_fid(frm_fid),
    .rt_valid(rt_valid), .rt_drop(rt_drop), .rt_ovr(rt_ovr), .rt_idx(rt_idx),
    .mem_we(mem_we), .mem_idx(mem_idx), .mem_word(mem_word)
);

// File: tb/test_frr_router.sv
`timescale 1ns/1ps
module test_frr_router;
    localparam int NBUF = 4, FDEPTH = 4, PLEN_W = 7, IDX_W = 3;
    localparam int FLEN = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic frm_start = 0, fifo_en = 1, fifo_pop = 0, wd_valid = 0;
    logic [11:0] frm_fid = '0;
    logic [PLEN_W-1:0] frm_len = '0, fifo_len = FLEN;
    logic [10:0] nss = 11'd10, rej_val = 11'd100, rej_mask = 11'h7FF;
    logic [NBUF-1:0] buf_en = 4'hF, buf_dyn = 4'b1010;
    logic [NBUF*11-1:0] buf_fid = {11'd10, 11'd3, 11'd11, 11'd3};
    logic [NBUF*PLEN_W-1:0] buf_len = {7'd1, 7'd8, 7'd2, 7'd4};
    logic [31:0] wd_data = '0;
    logic rt_valid, rt_drop, rt_ovr, mem_we;
    logic [IDX_W-1:0] rt_idx, mem_idx;
    logic [PLEN_W-1:0] mem_word;
    logic [31:0] mem_wdata;

    always #10 clk = ~clk;

    frr_router #(.NBUF(NBUF), .FDEPTH(FDEPTH), .PLEN_W(PLEN_W)) i_frr_router (
        .clk(clk), .rst(rst), .frm_start(frm_start), .frm_fid(frm_fid),
        .frm_len(frm_len), .nss(nss), .buf_en(buf_en), .buf_fid(buf_fid),
        .buf_dyn(buf_dyn), .buf_len(buf_len), .fifo_en(fifo_en),
        .fifo_len(fifo_len), .rej_val(rej_val), .rej_mask(rej_mask),
        .fifo_pop(fifo_pop), .wd_valid(wd_valid), .wd_data(wd_data),
        .rt_valid(rt_valid), .rt_drop(rt_drop), .rt_ovr(rt_ovr), .rt_idx(rt_idx),
        .mem_we(mem_we), .mem_idx(mem_idx), .mem_word(mem_word),
        .mem_wdata(mem_wdata)
    );

    int total = 0, bad = 0;
    int fput = 0, fcnt = 0;
    bit done = 0;
    logic [4:0]  rq[$];
    string       rtag[$];
    logic [41:0] wq[$];
    string       wtag[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pay(input int fid, input int k);
        return 32'hA000_0000 | (fid << 8) | k;
    endfunction

    // driver: push expectations, then drive the frame
    task automatic send(input int fid, input int len, input bit drop,
                        input int idx, input bit ovr, input int nstore,
                        input string req);
        rq.push_back({drop, ovr, idx[2:0]});
        rtag.push_back(req);
        for (int k = 0; k < nstore; k++) begin
            wq.push_back({idx[2:0], k[6:0], pay(fid, k)});
            wtag.push_back(req);
        end
        @(negedge clk);
        frm_start = 1; frm_fid = fid[11:0]; frm_len = len[6:0];
        @(negedge clk);
        frm_start = 0;
        for (int k = 0; k < len; k++) begin
            wd_valid = 1; wd_data = pay(fid, k);
            @(negedge clk);
        end
        wd_valid = 0;
        @(negedge clk);
    endtask

    task automatic fifo_frame(input int fid, input int len, input string req);
        bit ovr;
        int idx;
        ovr = (fcnt == FDEPTH);
        idx = NBUF + fput;
        fput = (fput + 1) % FDEPTH;
        if (!ovr) fcnt++;
        send(fid, len, 0, idx, ovr, (len < FLEN) ? len : FLEN, req);
    endtask

    task automatic pop();
        @(negedge clk);
        fifo_pop = 1;
        @(negedge clk);
        fifo_pop = 0;
        if (fcnt > 0) fcnt--;
    endtask

    // monitor: compare outputs against queued expectations
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rt_valid) begin
                if (rq.size() == 0)
                    check(0, "R1", "unexpected decision", {59'd0, rt_drop, rt_ovr, rt_idx}, 0);
                else begin
                    logic [4:0] e;
                    string t;
                    e = rq.pop_front();
                    t = rtag.pop_front();
                    check({rt_drop, rt_ovr, rt_idx} == e, t, "decision{drop,ovr,idx}",
                          {59'd0, rt_drop, rt_ovr, rt_idx}, {59'd0, e});
                end
            end
            if (mem_we) begin
                if (wq.size() == 0)
                    check(0, "R8", "unexpected write", {22'd0, mem_idx, mem_word, mem_wdata}, 0);
                else begin
                    logic [41:0] e;
                    string t;
                    e = wq.pop_front();
                    t = wtag.pop_front();
                    check({mem_idx, mem_word, mem_wdata} == e, t, "write{idx,word,data}",
                          {22'd0, mem_idx, mem_word, mem_wdata}, {22'd0, e});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!rt_valid && !mem_we, "R1", "reset outputs idle",
              {62'd0, rt_valid, mem_we}, 0);
        send(3, 6, 0, 0, 0, 4, "R3");       // R1, R3, R8: dup ID, truncated to 4
        send(3, 2, 0, 0, 0, 2, "R8");       // shorter than configured: all kept
        send(11, 5, 0, 1, 0, 2, "R2");     // first dynamic ID
        fifo_frame(10, 2, "R2");            // buffer 3 in wrong segment
        send(0, 2, 1, 0, 0, 0, "R4");
        send(2100, 2, 1, 0, 0, 0, "R4");
        fifo_frame(2047, 1, "R5");          // top legal ID, no buffer
        send(100, 2, 1, 0, 0, 0, "R5");     // rejected by filter
        fifo_en = 0;
        send(50, 2, 1, 0, 0, 0, "R5");      // FIFO switched off
        fifo_en = 1;
        fifo_frame(51, 5, "R8");            // FIFO truncation
        fifo_frame(52, 1, "R6");            // wraps put
        fifo_frame(53, 2, "R7");            // full: overrun
        pop();
        fifo_frame(54, 2, "R7");            // freed entry, no overrun
        fifo_frame(55, 2, "R7");
        nss = 11'd11;
        fifo_frame(11, 2, "R2");            // buffer 1 now out of its segment
        nss = 11'd10;
        repeat (5) pop();                   // last pop ignored
        fifo_frame(60, 3, "R6");
        fifo_frame(61, 3, "R6");
        repeat (4) @(negedge clk);
        check(rq.size() == 0, "R1", "pending decisions", rq.size(), 0);
        check(wq.size() == 0, "R9", "pending writes", wq.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule